// File: doc/BRIEF.md
# I2C Master Serial Clock Timing Generator

This block produces the serial clock waveform of an I2C controller acting as bus master. A programmable prescaler divides the functional clock into a sampling tick. The tick is also exported as a one-cycle strobe for the glitch filter and the bit logic. The low and high phases of the serial clock are then timed as whole numbers of ticks. Each phase has a fixed offset added to its programmed count: +7 for the low phase and +5 for the high phase.

Two sets of phase counts exist. One set serves Standard/Fast speed, which is also used for the first part of a high-speed transfer. The other set serves the high-speed data phase, during which the prescaler is bypassed and every functional clock cycle is a tick. The configuration fields are copied into shadow registers while the block is disabled and are frozen while it is enabled.

The controller sequences the block through three states. `ST_IDLE` keeps the line released. On the transition *start*, a tick with run requested moves it to `ST_LOW`. On the transition *low-done*, the last low tick moves it to `ST_HIGH`. On the transition *repeat*, the last high tick with run still requested moves it back to `ST_LOW`. On the transition *stop*, the last high tick with run withdrawn moves it to `ST_IDLE`. The transition *abort* returns it to `ST_IDLE` at once when the block is disabled or not in master mode.

Top module: `scl_wavegen`

## Requirements
- R1: After reset, `scl_o` is 1 (released) and `tick_o` is 0.
- R2: With `enable` high and the Standard/Fast rate in force, `tick_o` is a one-cycle pulse every (prescale + 1) functional clock cycles. A prescale of 0 gives a tick on every cycle.
- R3: In the high-speed data phase, the prescaler is bypassed and `tick_o` is high on every cycle while enabled.
- R4: The low phase lasts (low count + 7) ticks. The count is `low_cfg[7:0]` at Standard/Fast rate and `low_cfg[15:8]` in the high-speed phase. For example, prescale 9 with low count 7 gives 140 cycles, and high-speed low count 12 gives 19 cycles.
- R5: The high phase lasts (high count + 5) ticks. The count is `high_cfg[7:0]` at Standard/Fast rate and `high_cfg[15:8]` in the high-speed phase. For example, prescale 9 with high count 5 gives 100 cycles, and high-speed high count 5 gives 10 cycles.
- R6: While `master` is 0, no low phase starts, and `scl_o` is 1 from the cycle after `master` falls.
- R7: While idle, `scl_o` is 1. With `run` high, `scl_o` goes low in the cycle after the next tick.
- R8: The configuration inputs are captured on every clock while `enable` is 0. Changes to them while `enable` is 1 have no effect on the waveform or the tick rate.
- R9: When `enable` is 0, `tick_o` is 0 in the same cycle, and `scl_o` is 1 from the next cycle on. The rate also returns to Standard/Fast.
- R10: A change of `hs_sel` takes effect only at the next low-phase start. At that point the prescaler restarts from zero, and the current low/high cycle finishes at its old rate and counts.
- R11: If `run` is withdrawn, the current low and high phases still complete, and the block then stays idle with `scl_o` at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Functional clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| enable | input | 1 | Block enable; configuration is captured while low |
| master | input | 1 | 1 = master mode (clock generated), 0 = slave mode |
| run | input | 1 | Request to generate clock cycles |
| hs_sel | input | 1 | 1 = high-speed data phase, 0 = Standard/Fast rate |
| psc_cfg | input | PSC_W | Prescale value; tick period is psc_cfg + 1 cycles |
| low_cfg | input | 2*CNT_W | [15:8] high-speed low count, [7:0] Standard/Fast low count |
| high_cfg | input | 2*CNT_W | [15:8] high-speed high count, [7:0] Standard/Fast high count |
| scl_o | output | 1 | Serial clock level: 0 = drive low, 1 = released |
| tick_o | output | 1 | One-cycle sampling tick strobe |

## Verification
The first waveform pattern uses the reference Fast-mode settings: prescale 9 with counts 7 and 5. Its 140/100-cycle phases confirm both offsets and the prescaled tick together. A high-speed switch made in mid-cycle then separates the field selection and the prescaler bypass from the timing of the switch: the interrupted cycle must keep the old timing, and the next one must run at 19/10 cycles. A prescale-0 pattern with zero counts exercises the shortest phases. Withdrawn run, slave mode, disable and configuration writes made while enabled each show whether the line is released and whether frozen settings stay frozen. A behavioural model compared on every clock catches any cycle offset in between.

// File: rtl/scl_pkg.sv
package scl_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_LOW  = 2'd1,
        ST_HIGH = 2'd2
    } scl_state_e;

endpackage

// File: rtl/scl_cfg_shadow.sv
module scl_cfg_shadow #(
    parameter int PSC_W = 8,
    parameter int CNT_W = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 enable,
    input  logic [PSC_W-1:0]     psc_in,
    input  logic [2*CNT_W-1:0]   low_in,
    input  logic [2*CNT_W-1:0]   high_in,
    output logic [PSC_W-1:0]     psc_q,
    output logic [2*CNT_W-1:0]   low_q,
    output logic [2*CNT_W-1:0]   high_q
);

    // Shadow copies follow the inputs only while the block is disabled.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            psc_q  <= '0;
            low_q  <= '0;
            high_q <= '0;
        end else if (!enable) begin
            psc_q  <= psc_in;
            low_q  <= low_in;
            high_q <= high_in;
        end
    end

endmodule

// File: rtl/scl_presc.sv
module scl_presc #(
    parameter int PSC_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic             bypass,
    input  logic             restart,
    input  logic [PSC_W-1:0] psc,
    output logic             tick
);

    logic [PSC_W-1:0] div_q;
    logic             wrap;

    assign wrap = (div_q == psc);
    assign tick = enable & (bypass | wrap);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            div_q <= '0;
        end else if (!enable || bypass || restart || wrap) begin
            div_q <= '0;
        end else begin
            div_q <= div_q + PSC_W'(1);
        end
    end

endmodule

// File: rtl/scl_len_sel.sv
module scl_len_sel #(
    parameter int CNT_W    = 8,
    parameter int LOW_ADD  = 7,
    parameter int HIGH_ADD = 5,
    localparam int LEN_W   = CNT_W + 1
) (
    input  logic               hs,
    input  logic [2*CNT_W-1:0] low_q,
    input  logic [2*CNT_W-1:0] high_q,
    output logic [LEN_W-1:0]   low_len,
    output logic [LEN_W-1:0]   high_len
);

    logic [CNT_W-1:0] low_fld [2];
    logic [CNT_W-1:0] high_fld [2];

    // Slot 0 holds the Standard/Fast field, slot 1 the high-speed field.
    for (genvar g = 0; g < 2; g++) begin : g_fld
        assign low_fld[g]  = low_q[g*CNT_W +: CNT_W];
        assign high_fld[g] = high_q[g*CNT_W +: CNT_W];
    end

    always_comb begin
        low_len  = {1'b0, low_fld[hs]}  + LEN_W'(LOW_ADD);
        high_len = {1'b0, high_fld[hs]} + LEN_W'(HIGH_ADD);
    end

endmodule

// File: rtl/scl_phase_fsm.sv
module scl_phase_fsm
    import scl_pkg::*;
#(
    parameter int CNT_W  = 8,
    localparam int LEN_W = CNT_W + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic             master,
    input  logic             run,
    input  logic             hs_req,
    input  logic             tick,
    input  logic [LEN_W-1:0] low_len,
    input  logic [LEN_W-1:0] high_len,
    output logic             hs_eff,
    output logic             phase_start,
    output logic             scl_o
);

    scl_state_e       state_q, state_n;
    logic [LEN_W-1:0] cnt_q, cnt_n;
    logic             hs_n;
    logic             low_done, high_done;

    assign low_done  = (cnt_q == low_len - LEN_W'(1));
    assign high_done = (cnt_q == high_len - LEN_W'(1));

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
            hs_eff  <= 1'b0;
        end else begin
            state_q <= state_n;
            cnt_q   <= cnt_n;
            hs_eff  <= hs_n;
        end
    end

    // Transitions
    always_comb begin
        state_n     = state_q;
        cnt_n       = cnt_q;
        hs_n        = hs_eff;
        phase_start = 1'b0;
        if (!enable) begin
            state_n = ST_IDLE;
            cnt_n   = '0;
            hs_n    = 1'b0;
        end else if (!master) begin
            state_n = ST_IDLE;
            cnt_n   = '0;
        end else if (tick) begin
            unique case (state_q)
                ST_IDLE: begin
                    if (run) begin
                        phase_start = 1'b1;
                    end
                end
                ST_LOW: begin
                    if (low_done) begin
                        state_n = ST_HIGH;
                        cnt_n   = '0;
                    end else begin
                        cnt_n = cnt_q + LEN_W'(1);
                    end
                end
                ST_HIGH: begin
                    if (high_done) begin
                        if (run) begin
                            phase_start = 1'b1;
                        end else begin
                            state_n = ST_IDLE;
                            cnt_n   = '0;
                        end
                    end else begin
                        cnt_n = cnt_q + LEN_W'(1);
                    end
                end
                default: begin
                    state_n = ST_IDLE;
                    cnt_n   = '0;
                end
            endcase
            if (phase_start) begin
                state_n = ST_LOW;
                cnt_n   = '0;
                hs_n    = hs_req;
            end
        end
    end

    // Outputs
    always_comb begin
        unique case (state_q)
            ST_LOW:  scl_o = 1'b0;
            ST_HIGH: scl_o = 1'b1;
            default: scl_o = 1'b1;
        endcase
    end

endmodule

// File: rtl/scl_wavegen.sv
module scl_wavegen #(
    parameter int PSC_W    = 8,
    parameter int CNT_W    = 8,
    parameter int LOW_ADD  = 7,
    parameter int HIGH_ADD = 5,
    localparam int LEN_W   = CNT_W + 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               enable,
    input  logic               master,
    input  logic               run,
    input  logic               hs_sel,
    input  logic [PSC_W-1:0]   psc_cfg,
    input  logic [2*CNT_W-1:0] low_cfg,
    input  logic [2*CNT_W-1:0] high_cfg,
    output logic               scl_o,
    output logic               tick_o
);

    logic [PSC_W-1:0]   psc_sh;
    logic [2*CNT_W-1:0] low_sh;
    logic [2*CNT_W-1:0] high_sh;
    logic [LEN_W-1:0]   low_len;
    logic [LEN_W-1:0]   high_len;
    logic               hs_eff;
    logic               phase_start;
    logic               tick;

    scl_cfg_shadow #(.PSC_W(PSC_W), .CNT_W(CNT_W)) u_shadow (
        .clk     (clk),
        .rst_n   (rst_n),
        .enable  (enable),
        .psc_in  (psc_cfg),
        .low_in  (low_cfg),
        .high_in (high_cfg),
        .psc_q   (psc_sh),
        .low_q   (low_sh),
        .high_q  (high_sh)
    );

    scl_presc #(.PSC_W(PSC_W)) u_presc (
        .clk     (clk),
        .rst_n   (rst_n),
        .enable  (enable),
        .bypass  (hs_eff),
        .restart (phase_start),
        .psc     (psc_sh),
        .tick    (tick)
    );

    scl_len_sel #(.CNT_W(CNT_W), .LOW_ADD(LOW_ADD), .HIGH_ADD(HIGH_ADD)) u_len (
        .hs       (hs_eff),
        .low_q    (low_sh),
        .high_q   (high_sh),
        .low_len  (low_len),
        .high_len (high_len)
    );

    scl_phase_fsm #(.CNT_W(CNT_W)) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .enable      (enable),
        .master      (master),
        .run         (run),
        .hs_req      (hs_sel),
        .tick        (tick),
        .low_len     (low_len),
        .high_len    (high_len),
        .hs_eff      (hs_eff),
        .phase_start (phase_start),
        .scl_o       (scl_o)
    );

    assign tick_o = tick;

endmodule

// File: rtl/scl_wavegen_chk.sv
module scl_wavegen_chk #(
    parameter int PSC_W = 8,
    parameter int CNT_W = 8
) (
    input logic               clk,
    input logic               rst_n,
    input logic               enable,
    input logic               master,
    input logic               run,
    input logic               scl_o,
    input logic               tick_o,
    input logic [PSC_W-1:0]   psc_q,
    input logic [2*CNT_W-1:0] low_q,
    input logic [2*CNT_W-1:0] high_q
);

    a_r9_no_tick_when_off: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |-> !tick_o);

    a_r6_slave_releases: assert property (@(posedge clk) disable iff (!rst_n)
        !master |=> scl_o);

    a_r7_fall_on_tick_with_run: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(scl_o) |-> ($past(tick_o) && $past(run) && $past(master) && $past(enable)));

    a_r4_rise_on_tick_or_abort: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(scl_o) |-> ($past(tick_o) || !$past(enable) || !$past(master)));

    a_r8_cfg_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && $past(enable)) |-> ($stable(psc_q) && $stable(low_q) && $stable(high_q)));

endmodule

bind scl_wavegen scl_wavegen_chk #(.PSC_W(PSC_W), .CNT_W(CNT_W)) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .enable (enable),
    .master (master),
    .run    (run),
    .scl_o  (scl_o),
    .tick_o (tick_o),
    .psc_q  (psc_sh),
    .low_q  (low_sh),
    .high_q (high_sh)
);

// File: tb/sim_scl_wavegen.sv
module sim_scl_wavegen;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 20000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        enable = 1'b0;
    logic        master = 1'b1;
    logic        run = 1'b0;
    logic        hs_sel = 1'b0;
    logic [7:0]  psc_cfg = '0;
    logic [15:0] low_cfg = '0;
    logic [15:0] high_cfg = '0;
    logic        scl_o;
    logic        tick_o;

    int    n_chk = 0;
    int    n_bad = 0;
    int    cyc = 0;
    string cur = "R1";

    always #(CLK_PERIOD/2) clk = ~clk;

    scl_wavegen u0 (
        .clk(clk), .rst_n(rst_n), .enable(enable), .master(master), .run(run),
        .hs_sel(hs_sel), .psc_cfg(psc_cfg), .low_cfg(low_cfg), .high_cfg(high_cfg),
        .scl_o(scl_o), .tick_o(tick_o)
    );

    // Behavioural reference: phase length counted down in ticks.
    int          m_div, m_left, m_mode;   // m_mode: 0 idle, 1 low, 2 high
    logic        m_hs;
    logic [7:0]  m_psc;
    logic [15:0] m_low, m_high;
    logic        exp_tick, exp_scl;

    function automatic int len_of(logic [15:0] w, logic hs, int add);
        return int'(hs ? w[15:8] : w[7:0]) + add;
    endfunction

    assign exp_tick = enable && (m_hs || m_div == int'(m_psc));
    assign exp_scl  = (m_mode != 1);

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_div <= 0; m_left <= 0; m_mode <= 0; m_hs <= 1'b0;
            m_psc <= '0; m_low <= '0; m_high <= '0;
        end else if (!enable) begin
            m_psc <= psc_cfg; m_low <= low_cfg; m_high <= high_cfg;
            m_div <= 0; m_hs <= 1'b0; m_mode <= 0;
        end else begin
            m_div <= (exp_tick || m_hs) ? 0 : m_div + 1;
            if (!master) begin
                m_mode <= 0;
            end else if (exp_tick) begin
                if (m_mode == 0 && run) begin
                    m_mode <= 1; m_hs <= hs_sel; m_div <= 0;
                    m_left <= len_of(m_low, hs_sel, 7);
                end else if (m_mode == 1) begin
                    if (m_left == 1) begin
                        m_mode <= 2; m_left <= len_of(m_high, m_hs, 5);
                    end else m_left <= m_left - 1;
                end else if (m_mode == 2) begin
                    if (m_left == 1) begin
                        if (run) begin
                            m_mode <= 1; m_hs <= hs_sel; m_div <= 0;
                            m_left <= len_of(m_low, hs_sel, 7);
                        end else m_mode <= 0;
                    end else m_left <= m_left - 1;
                end
            end
        end
    end

    task automatic check(string tag, string what, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    // Per-cycle comparison against the model
    always @(negedge clk) begin
        if (rst_n) begin
            check(cur, "scl_o", int'(scl_o), int'(exp_scl));
            check(cur, "tick_o", int'(tick_o), int'(exp_tick));
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > WATCHDOG) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual %0d expected below %0d", cyc, WATCHDOG);
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    task automatic step(int n);
        repeat (n) @(posedge clk);
        #2;
    endtask

    // Skips the cycle in progress and measures the next full low/high pair.
    task automatic meas(output int lo, output int hi);
        @(negedge clk);
        while (!scl_o) @(negedge clk);
        while (scl_o) @(negedge clk);
        lo = 0;
        while (!scl_o) begin lo++; @(negedge clk); end
        hi = 0;
        while (scl_o) begin hi++; @(negedge clk); end
    endtask

    initial begin
        int lo, hi;
        step(4);
        @(negedge clk);
        check("R1", "reset scl_o", int'(scl_o), 1);
        check("R1", "reset tick_o", int'(tick_o), 0);
        rst_n = 1'b1;
        step(2);

        // Fast-mode programming while disabled
        cur = "R2";
        psc_cfg = 8'd9; low_cfg = 16'h0C07; high_cfg = 16'h0505;
        step(2);
        enable = 1'b1;
        step(35);

        cur = "R7";
        run = 1'b1;
        step(1);
        // R8: writes while enabled must not change anything
        psc_cfg = 8'd2; low_cfg = 16'h0000; high_cfg = 16'h0101;
        cur = "R4";
        meas(lo, hi);
        check("R4", "fast low cycles", lo, 140);
        check("R5", "fast high cycles", hi, 100);
        check("R8", "fast low after write while enabled", lo, 140);

        // R10: switch requested while a Fast cycle is in its low phase
        cur = "R10";
        step(3);
        hs_sel = 1'b1;
        meas(lo, hi);
        check("R3", "hs low cycles", lo, 19);
        check("R5", "hs high cycles", hi, 10);
        cur = "R3";
        step(40);

        cur = "R11";
        run = 1'b0;
        step(60);
        @(negedge clk);
        check("R11", "scl idle after run drop", int'(scl_o), 1);

        cur = "R6";
        run = 1'b1;
        step(13);
        master = 1'b0;
        step(30);
        @(negedge clk);
        check("R6", "slave scl released", int'(scl_o), 1);
        master = 1'b1;
        step(30);

        cur = "R9";
        enable = 1'b0;
        #1;
        check("R9", "tick off when disabled", int'(tick_o), 0);
        step(1);
        @(negedge clk);
        check("R9", "scl released when disabled", int'(scl_o), 1);
        psc_cfg = 8'd0; low_cfg = 16'h0000; high_cfg = 16'h0000; hs_sel = 1'b0;
        step(2);
        enable = 1'b1;
        cur = "R2";
        meas(lo, hi);
        check("R4", "min low cycles", lo, 7);
        check("R5", "min high cycles", hi, 5);
        run = 1'b0;
        step(20);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule